// File: doc/BRIEF.md
# Single/Double-Length Shift Matrix

This block shifts either one 36-bit word or a 72-bit register pair, which it handles as one value, by any distance from 0 to 72 in a single clock. It offers five shift kinds: rotate right, rotate left, logical right, logical left and arithmetic right. It also offers a scale operation. Scaling rotates the value left until its two top bits differ and returns both the rotated value and the number of places it moved.

The caller presents the operand, a 7-bit distance, an operation code and a length select, then raises `start` for one cycle. One clock later the registered result and scale count appear and `done` pulses. The outputs then keep those values until the next `start`. Operand fetch and write-back belong to the surrounding datapath.

Top module: `shift_matrix`

## Requirements
- R1: While reset is held, and until the first start after it, `result` and `scale_cnt` are zero and `done` is low.
- R2: `done` is high in exactly the cycle after a `start` cycle, whatever the operation or distance. Without `start`, `result` and `scale_cnt` keep their values.
- R3: Code 0 rotates right by `count`. Bits leaving the low end re-enter at the high end.
- R4: Code 1 rotates left by `count`. Bits leaving the high end re-enter at the low end.
- R5: Code 2 is a logical right shift and code 3 is a logical left shift. Both fill vacated places with zeros and lose the bits shifted out.
- R6: Code 4 is an arithmetic right shift. Vacated high places take copies of the operand's top bit.
- R7: With `dbl`=1 the whole 72-bit `operand` is one value with bit 71 on top, and the first word sits in bits 71..36. With `dbl`=0 only `operand[35:0]` is used, the upper input bits are ignored, and `result[71:36]` is zero.
- R8: Code 5 (scale) rotates left until the two top bits of the selected length differ. `scale_cnt` gives the number of places moved. For every other code, `scale_cnt` is zero.
- R9: A scale of an all-zero or all-one value stops at length minus one, which is 35 or 71. That count is returned, and the value is unchanged.
- R10: Any distance from 0 to 72 is accepted at either length. A distance of 0 returns the operand unchanged. On a single word, rotation distances of 36 or more act modulo 36, and logical shifts of 36 or more give zero.
- R11: Codes 6 and 7 pass the selected operand through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch one operation this cycle |
| op | input | 3 | Operation code (0..7, see requirements) |
| dbl | input | 1 | 1 = 72-bit pair, 0 = single 36-bit word |
| count | input | 7 | Shift distance, 0..72 |
| operand | input | 72 | Value to shift; first word in bits 71..36 |
| result | output | 72 | Registered shifted value |
| scale_cnt | output | 7 | Places moved by the scale operation |
| done | output | 1 | Pulses the cycle after start |

## Verification
The bench builds the block with its defaults: a 36-bit word, a 72-bit pair and a 7-bit distance. With these values every distance up to the full pair width can be reached at both lengths. Single-word rotations past one word exercise the modulo behaviour, and the all-equal scale limit is reached at both 35 and 71. The distance stages for 32 and 64 are driven at both lengths, so the stages whose span exceeds the word wrap as rotations and clear as logical shifts.

// File: rtl/shift_matrix_pkg.sv
package shift_matrix_pkg;

  typedef enum logic [2:0] {
    OP_ROR   = 3'd0,
    OP_ROL   = 3'd1,
    OP_SRL   = 3'd2,
    OP_SLL   = 3'd3,
    OP_SRA   = 3'd4,
    OP_SCALE = 3'd5,
    OP_PASSA = 3'd6,
    OP_PASSB = 3'd7
  } shift_op_e;

  typedef enum logic [1:0] {
    FILL_ROT  = 2'd0,
    FILL_ZERO = 2'd1,
    FILL_SIGN = 2'd2
  } fill_e;

endpackage

// File: rtl/shift_barrel.sv
module shift_barrel
  import shift_matrix_pkg::*;
#(
  parameter int W     = 36,
  parameter int AMT_W = 7
) (
  input  logic [W-1:0]     val,
  input  logic [AMT_W-1:0] amt,
  input  logic             left,
  input  fill_e            fill,
  output logic [W-1:0]     out
);

  logic [W-1:0] stg [AMT_W+1];
  logic         sign_bit;

  assign sign_bit = val[W-1];
  assign stg[0]   = val;

  // one stage per distance bit; stage s moves by 2**s
  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int K  = 1 << s;
    localparam int KM = K % W;
    logic [W-1:0] moved;

    always_comb begin
      for (int i = 0; i < W; i++) begin
        int lo_src;
        int hi_src;
        lo_src = (i >= K) ? (i - K) : 0;
        hi_src = (i + K < W) ? (i + K) : (W - 1);
        if (fill == FILL_ROT) begin
          moved[i] = left ? stg[s][(i + W - KM) % W] : stg[s][(i + KM) % W];
        end else if (left) begin
          moved[i] = (i >= K) ? stg[s][lo_src] : 1'b0;
        end else begin
          moved[i] = (i + K < W) ? stg[s][hi_src]
                                 : ((fill == FILL_SIGN) ? sign_bit : 1'b0);
        end
      end
    end

    assign stg[s+1] = amt[s] ? moved : stg[s];
  end

  assign out = stg[AMT_W];

endmodule

// File: rtl/shift_sign_run.sv
module shift_sign_run #(
  parameter int W  = 36,
  parameter int CW = 7
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] run
);

  // number of bits below the top that match the top bit
  logic live;

  always_comb begin
    run  = '0;
    live = 1'b1;
    for (int i = W - 2; i >= 0; i--) begin
      if (live && (val[i] == val[W-1])) begin
        run = run + 1'b1;
      end else begin
        live = 1'b0;
      end
    end
  end

endmodule

// File: rtl/shift_matrix.sv
module shift_matrix
  import shift_matrix_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int CNT_W  = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [2:0]            op,
  input  logic                  dbl,
  input  logic [CNT_W-1:0]      count,
  input  logic [2*WORD_W-1:0]   operand,
  output logic [2*WORD_W-1:0]   result,
  output logic [CNT_W-1:0]      scale_cnt,
  output logic                  done
);

  localparam int DW    = 2 * WORD_W;
  localparam int N_LEN = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // operation decode
  shift_op_e op_e;
  logic      go_left;
  fill_e     fill_k;
  logic      is_scale;
  logic      is_pass;

  assign op_e = shift_op_e'(op);

  always_comb begin
    go_left  = 1'b0;
    fill_k   = FILL_ROT;
    is_scale = 1'b0;
    is_pass  = 1'b0;
    unique case (op_e)
      OP_ROR:   begin go_left = 1'b0; fill_k = FILL_ROT;  end
      OP_ROL:   begin go_left = 1'b1; fill_k = FILL_ROT;  end
      OP_SRL:   begin go_left = 1'b0; fill_k = FILL_ZERO; end
      OP_SLL:   begin go_left = 1'b1; fill_k = FILL_ZERO; end
      OP_SRA:   begin go_left = 1'b0; fill_k = FILL_SIGN; end
      OP_SCALE: begin go_left = 1'b1; fill_k = FILL_ROT; is_scale = 1'b1; end
      default:  begin is_pass = 1'b1; end
    endcase
  end

  // one datapath per operand length
  logic [DW-1:0]    res_len [N_LEN];
  logic [CNT_W-1:0] run_len [N_LEN];

  for (genvar L = 0; L < N_LEN; L++) begin : g_len
    localparam int LW = (L == 0) ? WORD_W : DW;
    logic [LW-1:0]    src;
    logic [LW-1:0]    shifted;
    logic [CNT_W-1:0] amt;

    assign src = operand[LW-1:0];

    shift_sign_run #(.W(LW), .CW(CNT_W)) u_run (
      .val (src),
      .run (run_len[L])
    );

    assign amt = is_scale ? run_len[L] : count;

    shift_barrel #(.W(LW), .AMT_W(CNT_W)) u_barrel (
      .val  (src),
      .amt  (amt),
      .left (go_left),
      .fill (fill_k),
      .out  (shifted)
    );

    assign res_len[L] = DW'(shifted);
  end

  // next state
  logic [DW-1:0]    result_q,    result_d;
  logic [CNT_W-1:0] scale_q,     scale_d;
  logic             done_q,      done_d;

  always_comb begin
    if (is_pass) begin
      result_d = dbl ? operand : DW'(operand[WORD_W-1:0]);
    end else begin
      result_d = res_len[dbl];
    end
    scale_d = is_scale ? run_len[dbl] : '0;
    done_d  = start;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      result_q <= '0;
      scale_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      if (start) begin
        result_q <= result_d;
        scale_q  <= scale_d;
      end
    end
  end

  assign result    = result_q;
  assign scale_cnt = scale_q;
  assign done      = done_q;

endmodule

// File: rtl/shift_matrix_chk.sv
module shift_matrix_chk #(
  parameter int WORD_W = 36,
  parameter int CNT_W  = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [2:0]          op,
  input logic                dbl,
  input logic [2*WORD_W-1:0] operand,
  input logic [2*WORD_W-1:0] result,
  input logic [CNT_W-1:0]    scale_cnt,
  input logic                done
);

  localparam int DW = 2 * WORD_W;

  p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  p_hold_outputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(scale_cnt)));

  p_single_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !dbl) |=> (result[DW-1:WORD_W] == '0));

  // covers R3 and R4: a rotation keeps the number of ones
  p_rotate_keeps_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dbl && (op == 3'd0 || op == 3'd1))
      |=> ($countones(result) == $countones($past(operand))));

  p_sra_keeps_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dbl && op == 3'd4) |=> (result[DW-1] == $past(operand[DW-1])));

  p_scale_normalised_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dbl && op == 3'd5)
      |=> ((result[DW-1] != result[DW-2]) || (scale_cnt == CNT_W'(DW - 1))));

  p_scale_zero_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op != 3'd5) |=> (scale_cnt == '0));

  p_scale_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !dbl && op == 3'd5) |=> (scale_cnt <= CNT_W'(WORD_W - 1)));

endmodule

bind shift_matrix shift_matrix_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (start),
  .op        (op),
  .dbl       (dbl),
  .operand   (operand),
  .result    (result),
  .scale_cnt (scale_cnt),
  .done      (done)
);

// File: tb/shift_matrix_tb.sv
`timescale 1ns/1ps
module shift_matrix_tb;

  localparam int WW = 36;
  localparam int DW = 72;
  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    op = 3'd0;
  logic          dbl = 1'b0;
  logic [CW-1:0] count = '0;
  logic [DW-1:0] operand = '0;
  logic [DW-1:0] result;
  logic [CW-1:0] scale_cnt;
  logic          done;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  shift_matrix u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .dbl       (dbl),
    .count     (count),
    .operand   (operand),
    .result    (result),
    .scale_cnt (scale_cnt),
    .done      (done)
  );

  // vector layout: [82:80] op, [79] dbl, [78:72] count, [71:0] operand
  localparam int NV = 18;
  localparam logic [82:0] VEC [NV] = '{
    {3'd0, 1'b0, 7'd4,  72'hABC_0001_2345_6789},
    {3'd0, 1'b1, 7'd40, 72'h01_2345_6789_ABCD_EF01},
    {3'd1, 1'b0, 7'd35, 72'h000_0008_0000_0013},
    {3'd1, 1'b1, 7'd1,  72'h80_0000_0000_0000_0005},
    {3'd2, 1'b0, 7'd36, 72'h000_000F_FFFF_FFFF},
    {3'd2, 1'b1, 7'd71, 72'hC0_0000_0000_0000_0000},
    {3'd3, 1'b0, 7'd12, 72'h555_0000_0123_4567},
    {3'd3, 1'b1, 7'd72, 72'hFF_FFFF_FFFF_FFFF_FFFF},
    {3'd4, 1'b0, 7'd5,  72'h000_000A_0000_00F0},
    {3'd4, 1'b1, 7'd72, 72'h80_0000_0000_0000_0000},
    {3'd4, 1'b1, 7'd30, 72'h7F_0000_0000_FFFF_0000},
    {3'd5, 1'b0, 7'd9,  72'h000_0000_0000_0FFF},
    {3'd5, 1'b1, 7'd0,  72'h00_0000_0000_0003_0000},
    {3'd5, 1'b1, 7'd3,  72'hFF_FF80_0000_0000_0001},
    {3'd0, 1'b0, 7'd0,  72'h123_000F_EDCB_A987},
    {3'd6, 1'b1, 7'd17, 72'h9A_BCDE_F012_3456_789A},
    {3'd1, 1'b0, 7'd72, 72'hFFF_0001_2340_0ABC},
    {3'd0, 1'b0, 7'd64, 72'h000_0008_7654_3210}
  };

  // reference: one place at a time
  function automatic logic [78:0] model(input logic [2:0] o, input logic d,
                                        input logic [6:0] n, input logic [71:0] x);
    int            w;
    logic [71:0]   v;
    logic [71:0]   mask;
    logic [6:0]    sc;
    logic          b;
    w    = d ? 72 : 36;
    mask = d ? {72{1'b1}} : {36'd0, {36{1'b1}}};
    v    = x & mask;
    sc   = '0;
    if (o == 3'd5) begin
      while (sc < 7'(w - 1) && v[w-1] == v[w-2]) begin
        b = v[w-1]; v = (v << 1) & mask; v[0] = b; sc = sc + 1'b1;
      end
    end else if (o <= 3'd4) begin
      for (int k = 0; k < int'(n); k++) begin
        case (o)
          3'd0: begin b = v[0]; v = v >> 1; v[w-1] = b; end
          3'd1: begin b = v[w-1]; v = (v << 1) & mask; v[0] = b; end
          3'd2: v = v >> 1;
          3'd3: v = (v << 1) & mask;
          default: begin b = v[w-1]; v = v >> 1; v[w-1] = b; end
        endcase
      end
    end
    return {sc, v};
  endfunction

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic d, input logic [6:0] n,
                        input logic [71:0] x);
    @(negedge clk);
    op = o; dbl = d; count = n; operand = x; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [78:0] e;
    logic [71:0] held;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 result in reset", result, '0);
    check("R1 scale_cnt in reset", 72'(scale_cnt), '0);
    check("R1 done in reset", 72'(done), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 result after release", result, '0);
    check("R1 done after release", 72'(done), '0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [82:0] t;
      t = VEC[i];
      run_op(t[82:80], t[79], t[78:72], t[71:0]);
      e = model(t[82:80], t[79], t[78:72], t[71:0]);
      check({req_of(t[82:80]), " R7 R10 result"}, result, e[71:0]);
      check("R8 scale_cnt", 72'(scale_cnt), 72'(e[78:72]));
      check("R2 done pulse", 72'(done), 72'd1);
    end

    // R2: hold without start
    run_op(3'd1, 1'b1, 7'd9, 72'h12_3456_789A_BCDE_F012);
    held = result;
    @(negedge clk);
    op = 3'd2; dbl = 1'b0; count = 7'd3; operand = '1;
    @(negedge clk);
    @(negedge clk);
    check("R2 done low when idle", 72'(done), 72'd0);
    check("R2 result held", result, held);

    // R6: arithmetic right of negative word
    run_op(3'd4, 1'b0, 7'd4, 72'h000_0008_0000_0000);
    check("R6 single sra", result, 72'h0_0000_000F_8000_0000);

    // R8: scale of one
    run_op(3'd5, 1'b0, 7'd0, 72'h0_0000_0000_0000_0001);
    check("R8 scale result", result, 72'h0_0000_0004_0000_0000);
    check("R8 scale count", 72'(scale_cnt), 72'd34);

    // R9: all zeros single, all ones double
    run_op(3'd5, 1'b0, 7'd5, 72'hFFF_FFF0_0000_0000);
    check("R9 zero word result", result, '0);
    check("R9 zero word count", 72'(scale_cnt), 72'd35);
    run_op(3'd5, 1'b1, 7'd5, {72{1'b1}});
    check("R9 ones pair result", result, {72{1'b1}});
    check("R9 ones pair count", 72'(scale_cnt), 72'd71);

    // R8: non-scale clears count
    run_op(3'd3, 1'b1, 7'd1, 72'h1);
    check("R8 count cleared", 72'(scale_cnt), 72'd0);
    check("R5 sll pair by one", result, 72'h2);

    // R10: logical right of pair by 72
    run_op(3'd2, 1'b1, 7'd72, {72{1'b1}});
    check("R10 srl pair by 72", result, '0);

    // R11: pass code in single length masks upper half
    run_op(3'd7, 1'b0, 7'd3, 72'hAB_CDEF_0123_4567_89AB);
    check("R11 pass single", result, 72'h0_0000_0123_4567_89AB & 72'h0_000F_FFFF_FFFF);

    summary();
    $finish;
  end

endmodule